// File: doc/BRIEF.md
# Phase-Picking Clock and Data Recovery

This block recovers a bit clock and bit data from two pulse-detect lines, one for positive and one for negative line pulses. It runs on a fast sampling clock. Each bit period of the recovered clock is split into `SLOTS` equal slots (13 by default). A free-running slot counter and a selected phase give a relative slot number. The recovered clock is high for the first `HIGH_SLOTS` relative slots and low for the rest. A pulse is expected in the centre slot. A pulse that lands more than `THRESH` slots away from the centre moves the phase by one slot toward it. Closer pulses leave the phase alone, and so does a long run of pulse-free periods.

The phase is kept by a small tracking state machine with four states. `TS_WAIT` holds after reset until the first pulse. `TS_HOLD` means the phase is settled. `TS_LATE` and `TS_EARLY` each hold a pending one-slot move. The transitions are: *first-pulse* (TS_WAIT to HOLD, LATE or EARLY, depending on where the pulse fell); *off-window* (any state to LATE or EARLY when a pulse lands outside the window); *in-window* (any state to HOLD when a pulse lands inside the window); and *apply* (LATE or EARLY to HOLD at the apply slot, where the phase register takes the step). A pending move is applied at the apply slot, `SLOTS/4` rounded down (slot 3 by default). The apply slot is away from both clock edges, so it never splits or repeats a bit boundary.

Pulses are gathered across a whole bit period and the result is latched at the period's end. The output alignment depends on the line mode. The pair mode is valid on the rising recovered-clock edge. The merged mode is valid on the falling edge. In the host mode, an edge-select input picks the alignment.

Top module: `phase_pick_cdr`

## Requirements
- R1: While the phase is unchanged, the recovered clock `rx_clk` repeats every `SLOTS` sampling clocks (13 by default).
- R2: Counted from a rising edge of `rx_clk`, the clock is high during slots 0..`HIGH_SLOTS`-1 (0..6) and low during slots 7..12.
- R3: After reset the phase is `RESET_PHASE` (6). `rx_clk` is low, and it first goes high on the 6th sampling-clock edge after reset is released. `rx_pos`, `rx_neg` and `rx_merged` stay low until the first pulse has been seen.
- R4: A pulse at a slot within `THRESH` (2) of the centre slot 6 leaves the phase unchanged, so the next period is still 13 clocks. With the defaults this window spans slots 4..8, about 0.4 UI.
- R5: A pulse at slot 9 or later moves the phase one slot later. A pulse at slot 3 or earlier moves it one slot earlier. The step is taken at the next apply slot (3), so the period that contains the step is 14 clocks (later) or 12 clocks (earlier).
- R6: During any run of pulse-free periods, the period stays at 13 clocks and the data outputs are low. A pulse that follows a run of 20 empty periods is recovered.
- R7: A pulse on `pulse_pos` or `pulse_neg` in any slot 0..12 of a period is reported as a one for that period's bit. `rx_merged` carries the OR of the two.
- R8: In pair mode (`line_mode` 00, with 11 treated the same way), `rx_pos` and `rx_neg` change only as `rx_clk` falls and carry the previous period's bit. `rx_merged` is low.
- R9: In merged mode (`line_mode` 01), `rx_merged` changes only as `rx_clk` rises and carries the previous period's bit. `rx_pos` and `rx_neg` are low.
- R10: In host mode (`line_mode` 10), all three data outputs are driven. With `edge_sel` = 0 they use the R8 alignment, and with `edge_sel` = 1 they use the R9 alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, `SLOTS` cycles per bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_pos | input | 1 | Positive pulse detected in this slot |
| pulse_neg | input | 1 | Negative pulse detected in this slot |
| line_mode | input | 2 | 00 pair, 01 merged, 10 host, 11 as pair |
| edge_sel | input | 1 | Host mode alignment: 0 rising-valid, 1 falling-valid |
| rx_pos | output | 1 | Recovered positive-pulse data |
| rx_neg | output | 1 | Recovered negative-pulse data |
| rx_merged | output | 1 | Recovered merged data |
| rx_clk | output | 1 | Recovered bit clock |

## Verification
The bench uses the default parameters: 13 slots, a threshold of 2, a reset phase of 6, 7 high slots and an apply slot of 3. With these values, pulses at slots 4..8 fall inside the window. Slots 3 and 9 are the nearest offsets that cause a step, and slot 12 is the last slot before the bit boundary. The bench locks onto `rx_clk` rises, so slot positions come from the port alone. Each period is sampled at slot 3, where the rising-valid and falling-valid outputs still hold different bits, and again at slot 9, where both hold the previous bit. A step is seen as a 14-clock or 12-clock period.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    typedef enum logic [1:0] {
        LM_PAIR   = 2'b00,
        LM_MERGED = 2'b01,
        LM_HOST   = 2'b10,
        LM_SPARE  = 2'b11
    } line_mode_e;

    typedef enum logic [1:0] {
        TS_WAIT  = 2'b00,
        TS_HOLD  = 2'b01,
        TS_LATE  = 2'b10,
        TS_EARLY = 2'b11
    } track_state_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } mark_pair_t;

endpackage

// File: rtl/cdr_slot_counter.sv
module cdr_slot_counter #(
    parameter int SLOTS = 13,
    parameter int SW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] slot
);

    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (slot == LAST) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // R1: the counter never leaves its range
    assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot < SW'(SLOTS));

    // R1: it steps by one below the wrap point
    assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != LAST) |=> (slot == $past(slot) + 1'b1));

endmodule

// File: rtl/cdr_phase_tracker.sv
module cdr_phase_tracker import cdr_pkg::*; #(
    parameter int SLOTS       = 13,
    parameter int SW          = 4,
    parameter int THRESH      = 2,
    parameter int RESET_PHASE = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] slot,
    input  logic          pulse_any,
    output logic [SW-1:0] phase,
    output logic [SW-1:0] rel,
    output logic          waiting
);

    localparam int CENTER    = SLOTS / 2;
    localparam int LATE_LIM  = CENTER + THRESH;
    localparam int EARLY_LIM = CENTER - THRESH;
    localparam int APPLY     = CENTER / 2;

    track_state_e state, state_nxt, cls;
    logic [SW:0]  wrap_sum;
    logic         is_late, is_early, at_apply;

    function automatic logic [SW-1:0] step_up(input logic [SW-1:0] p);
        return (p == SW'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [SW-1:0] step_dn(input logic [SW-1:0] p);
        return (p == '0) ? SW'(SLOTS - 1) : p - 1'b1;
    endfunction

    // slot position measured from the selected phase
    always_comb begin
        wrap_sum = {1'b0, slot} + (SW+1)'(SLOTS) - {1'b0, phase};
        rel      = (slot >= phase) ? (slot - phase) : wrap_sum[SW-1:0];
    end

    assign is_late  = int'(rel) > LATE_LIM;
    assign is_early = int'(rel) < EARLY_LIM;
    assign at_apply = (rel == SW'(APPLY));
    assign waiting  = (state == TS_WAIT);

    always_comb begin
        if (is_late) begin
            cls = TS_LATE;
        end else if (is_early) begin
            cls = TS_EARLY;
        end else begin
            cls = TS_HOLD;
        end
    end

    // next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            TS_WAIT:  state_nxt = pulse_any ? cls : TS_WAIT;
            TS_HOLD:  state_nxt = pulse_any ? cls : TS_HOLD;
            TS_LATE,
            TS_EARLY: begin
                if (pulse_any) begin
                    state_nxt = cls;
                end else if (at_apply) begin
                    state_nxt = TS_HOLD;
                end
            end
            default:  state_nxt = TS_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TS_WAIT;
        end else begin
            state <= state_nxt;
        end
    end

    // phase register, stepped only by a pending move at the apply slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= SW'(RESET_PHASE);
        end else if (at_apply) begin
            unique case (state)
                TS_LATE:  phase <= step_up(phase);
                TS_EARLY: phase <= step_dn(phase);
                default:  phase <= phase;
            endcase
        end
    end

    // R5: the phase moves by one slot at most
    assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |->
            ((phase == step_up($past(phase))) || (phase == step_dn($past(phase)))));

    // R3: before the first pulse the reset phase is kept
    assert_wait_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> (phase == SW'(RESET_PHASE)));

endmodule

// File: rtl/cdr_bit_sampler.sv
module cdr_bit_sampler import cdr_pkg::*; #(
    parameter int SLOTS      = 13,
    parameter int SW         = 4,
    parameter int HIGH_SLOTS = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] rel,
    input  mark_pair_t    mark,
    input  logic          waiting,
    input  line_mode_e    mode,
    input  logic          edge_sel,
    output logic          rx_pos,
    output logic          rx_neg,
    output logic          rx_merged,
    output logic          rx_clk
);

    mark_pair_t acc, bit_q, rise_q, src;
    logic       boundary, launch_fall, fall_sel, pair_en, mrg_en;

    assign boundary    = (rel == SW'(SLOTS - 1));
    assign launch_fall = (rel == SW'(HIGH_SLOTS - 1));
    assign rx_clk      = (rel < SW'(HIGH_SLOTS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            bit_q  <= '0;
            rise_q <= '0;
        end else begin
            if (boundary) begin
                bit_q <= mark_pair_t'(acc | mark);
                acc   <= '0;
            end else begin
                acc   <= mark_pair_t'(acc | mark);
            end
            if (launch_fall) begin
                rise_q <= bit_q;
            end
        end
    end

    always_comb begin
        fall_sel  = (mode == LM_MERGED) || ((mode == LM_HOST) && edge_sel);
        pair_en   = (mode != LM_MERGED);
        mrg_en    = (mode == LM_MERGED) || (mode == LM_HOST);
        src       = fall_sel ? bit_q : rise_q;
        rx_pos    = !waiting && pair_en && src.pos;
        rx_neg    = !waiting && pair_en && src.neg;
        rx_merged = !waiting && mrg_en && (src.pos || src.neg);
    end

    // R8: rising-valid data only changes as the recovered clock falls
    assert_rise_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q != $past(rise_q)) |-> $fell(rx_clk));

    // R9: falling-valid data only changes as the recovered clock rises
    assert_fall_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q != $past(bit_q)) |-> $rose(rx_clk));

endmodule

// File: rtl/phase_pick_cdr.sv
module phase_pick_cdr import cdr_pkg::*; #(
    parameter int SLOTS       = 13,
    parameter int THRESH      = 2,
    parameter int RESET_PHASE = 6,
    parameter int HIGH_SLOTS  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_pos,
    input  logic       pulse_neg,
    input  logic [1:0] line_mode,
    input  logic       edge_sel,
    output logic       rx_pos,
    output logic       rx_neg,
    output logic       rx_merged,
    output logic       rx_clk
);

    localparam int SW = $clog2(SLOTS);

    logic [SW-1:0] slot, phase, rel;
    logic          waiting;
    mark_pair_t    mark;
    line_mode_e    mode_e;

    assign mark   = '{pos: pulse_pos, neg: pulse_neg};
    assign mode_e = line_mode_e'(line_mode);

    cdr_slot_counter #(.SLOTS(SLOTS), .SW(SW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    cdr_phase_tracker #(
        .SLOTS(SLOTS), .SW(SW), .THRESH(THRESH), .RESET_PHASE(RESET_PHASE)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .pulse_any (pulse_pos || pulse_neg),
        .phase     (phase),
        .rel       (rel),
        .waiting   (waiting)
    );

    cdr_bit_sampler #(.SLOTS(SLOTS), .SW(SW), .HIGH_SLOTS(HIGH_SLOTS)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rel       (rel),
        .mark      (mark),
        .waiting   (waiting),
        .mode      (mode_e),
        .edge_sel  (edge_sel),
        .rx_pos    (rx_pos),
        .rx_neg    (rx_neg),
        .rx_merged (rx_merged),
        .rx_clk    (rx_clk)
    );

endmodule

// File: tb/tb_phase_pick_cdr.sv
module tb_phase_pick_cdr;

    localparam int SLOTS  = 13;
    localparam int CENTER = 6;
    localparam int NVEC   = 16;

    // vector: [7:6] line_mode, [5] edge_sel, [4] pos, [3] neg, [2:0] signed offset
    localparam logic [7:0] VEC [NVEC] = '{
        8'b00_0_0_0_000, 8'b00_0_1_0_000, 8'b00_0_0_1_010, 8'b00_0_1_1_110,
        8'b01_0_0_0_001, 8'b01_0_1_0_111, 8'b01_0_0_1_000, 8'b10_0_1_0_010,
        8'b10_0_0_1_110, 8'b10_1_1_0_000, 8'b10_1_0_0_001, 8'b10_1_0_1_111,
        8'b11_0_1_0_000, 8'b11_0_0_0_010, 8'b00_0_1_1_000, 8'b01_1_0_0_000
    };

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       pulse_pos = 1'b0, pulse_neg = 1'b0, edge_sel = 1'b0;
    logic [1:0] line_mode = 2'b00;
    logic       rx_pos, rx_neg, rx_merged, rx_clk;
    int         total = 0, bad = 0;

    always #4 clk = ~clk;

    phase_pick_cdr dut (
        .clk(clk), .rst_n(rst_n), .pulse_pos(pulse_pos), .pulse_neg(pulse_neg),
        .line_mode(line_mode), .edge_sel(edge_sel),
        .rx_pos(rx_pos), .rx_neg(rx_neg), .rx_merged(rx_merged), .rx_clk(rx_clk)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int outs();
        return {29'b0, rx_pos, rx_neg, rx_merged};
    endfunction

    // one bit period starting at relative slot 0; pulse at CENTER+off
    task automatic send_bit(input logic pos, input logic neg, input int off,
                            input bit do_chk, input int e3, input int e9,
                            input string tag3);
        for (int s = 0; s < SLOTS; s++) begin
            pulse_pos = pos && (s == CENTER + off);
            pulse_neg = neg && (s == CENTER + off);
            #1;
            if (s == 2)  chk("R2 clock high", int'(rx_clk), 1);
            if (s == 10) chk("R2 clock low", int'(rx_clk), 0);
            if (do_chk && s == 3) chk(tag3, outs(), e3);
            if (do_chk && s == 9) chk("R7 previous bit", outs(), e9);
            @(negedge clk);
        end
        pulse_pos = 1'b0;
        pulse_neg = 1'b0;
    endtask

    // clocks from the current rise to the next rise of rx_clk
    task automatic measure_period(output int n);
        logic prev = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (rx_clk && !prev) break;
            prev = rx_clk;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, zbad;
        logic p1, n1, p2, n2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R3 clock low after reset", int'(rx_clk), 0);
        chk("R3 data low after reset", outs(), 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rx_clk && n < 40);
        chk("R3 first rise edge count", n, 6);

        p1 = 0; n1 = 0; p2 = 0; n2 = 0;
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] v;
            logic fall, pe, me;
            int e3, e9;
            string tag;
            v = VEC[i];
            line_mode = v[7:6];
            edge_sel  = v[5];
            fall = (v[7:6] == 2'b01) || (v[7:6] == 2'b10 && v[5]);
            pe   = (v[7:6] != 2'b01);
            me   = (v[7:6] == 2'b01) || (v[7:6] == 2'b10);
            e9 = {29'b0, pe & p1, pe & n1, me & (p1 | n1)};
            e3 = fall ? e9 : {29'b0, pe & p2, pe & n2, me & (p2 | n2)};
            if (v[7:6] == 2'b01)      tag = "R9 merged alignment";
            else if (v[7:6] == 2'b10) tag = "R10 host alignment";
            else                      tag = "R8 pair alignment";
            send_bit(v[4], v[3], int'($signed(v[2:0])), 1'b1, e3, e9, tag);
            p2 = p1; n2 = n1;
            p1 = v[4]; n1 = v[3];
        end

        line_mode = 2'b00;
        edge_sel  = 1'b0;
        measure_period(n);
        chk("R1 period", n, 13);

        send_bit(1'b1, 1'b0, 2, 1'b0, 0, 0, "");
        measure_period(n);
        chk("R4 in-window pulse keeps phase", n, 13);

        send_bit(1'b1, 1'b0, 3, 1'b0, 0, 0, "");
        measure_period(n);
        chk("R5 late step period", n, 14);

        send_bit(1'b0, 1'b1, -3, 1'b0, 0, 0, "");
        measure_period(n);
        chk("R5 early step period", n, 12);

        zbad = 0;
        for (int k = 0; k < 20; k++) begin
            measure_period(n);
            if (n != 13) zbad++;
        end
        chk("R6 period steady over zeros", zbad, 0);
        #1;
        chk("R6 data low over zeros", outs(), 0);

        send_bit(1'b1, 1'b1, 0, 1'b0, 0, 0, "");
        send_bit(1'b0, 1'b0, 0, 1'b1, 0, 6, "R6 recovery slot 3");

        line_mode = 2'b01;
        send_bit(1'b1, 1'b0, 6, 1'b0, 0, 0, "");
        send_bit(1'b0, 1'b0, 0, 1'b1, 1, 1, "R7 last-slot pulse");
        measure_period(n);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule